// File: doc/BRIEF.md
# Dot-Matrix Display Host Register File

This block is the processor side of an eight-digit, 5x7 dot-matrix display controller. A host drives a slow, strobe-based bus: an active-low enable, separate active-low write and read strobes, a bank-select line, five address lines, and eight data bits. The bus is split here into a write-data input and a read-data output. The block holds four things:

- the code shown on each digit;
- an index register that points at one custom glyph;
- the row patterns of sixteen custom glyphs;
- a control word that includes a self-clearing "blank all digits" command.

Writes are taken from the bus while the write strobe is low. They are committed once the end of the strobe has been synchronised into the system clock. Reads are combinational and return data only while a read is in progress. The refresh and scan logic reads the stored codes and patterns through its own paths. Those paths are not part of this block.

Top module: `disp_host_regs`

## Requirements
- R1: On a clock edge with `rst_n` low, the control word and the glyph index register become 0, and every digit holds 0x20 (space).
- R2: A write happens only with `ce_n`=0, `wr_n`=0, `rd_n`=1 and `bank_sel`=1. A strobe with `ce_n`=1, or with `bank_sel`=0, changes no stored value.
- R3: `addr[4:3]`=2'b11 selects the digit store. `addr[2:0]` picks digit 0 (leftmost) to 7 (rightmost), and each digit reads back what was written to it.
- R4: A digit write with data bit 7 = 0 stores {0, data[6:0]} as a 7-bit character code. With bit 7 = 1 it stores {1, 000, data[3:0]}, a glyph index. Reads return the stored form.
- R5: `addr[4:3]`=2'b00 selects the glyph index register. It stores data[3:0], ignores data[7:4] and `addr[2:0]`, and reads back as {0000, index}.
- R6: `addr[4:3]`=2'b01 reaches row `addr[2:0]` (0..6) of the glyph named by the index register. Only data[4:0] is stored, where 1 = LED lit, and reads return {000, row}. Each glyph keeps its own rows.
- R7: A write to row 7 of a glyph is dropped, and a read of row 7 returns 0x00.
- R8: `addr[4:3]`=2'b10 selects the control word, which reads back and appears on `ctrl_word`. Bit 0 is blink enable, bit 1 is clock-source select, and bit 7 is the clear command. Bit 7 reads as 0 one clock after it is set.
- R9: Setting the clear bit loads 0x20 into all eight digits. It leaves the other control bits, the glyph index and the glyph rows unchanged.
- R10: A write takes effect only after `wr_n` (or `ce_n`) returns high. While the strobe is still low, no stored value has changed.
- R11: `rdata` is 0x00 unless `ce_n`=0, `rd_n`=0 and `wr_n`=1 together with `bank_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Bus enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| bank_sel | input | 1 | Selects this register bank when 1 |
| addr | input | 5 | Register and entry address |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Read data to host, zero when idle |
| ctrl_word | output | 8 | Current control word |

## Verification
Two things can collide in one clock:

- the self-clearing blank command, which rewrites every digit;
- a digit write that commits on the same edge.

The bench provokes this by storing a glyph index in a digit and then issuing the clear. It checks that the clear, which has priority, leaves 0x20 in that digit. It also checks that the blink and clock-select bits and the glyph rows come through unchanged.

The second overlap is a write still in flight while its effect is observed. The bench holds the strobe low over several clocks and checks that `ctrl_word` keeps its old value until after the strobe ends.

// File: rtl/disp_host_pkg.sv
// Package: shared sizes, address decode codes and control-bit positions
// for the display host register file. Assumes a five-bit host address
// whose top two bits pick the target store.
package disp_host_pkg;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 5;
    localparam logic [7:0] BLANK_CODE = 8'h20;

    // Target store selected by addr[4:3]; the decode is fixed behaviour.
    typedef enum logic [1:0] {
        TGT_UDC_IDX = 2'b00,
        TGT_UDC_ROW = 2'b01,
        TGT_CTRL    = 2'b10,
        TGT_DIGIT   = 2'b11
    } target_e;

    // Control word bit positions.
    localparam int CTL_BLINK  = 0;
    localparam int CTL_CLKSEL = 1;
    localparam int CTL_CLEAR  = 7;
endpackage

// File: rtl/host_write_sync.sv
// host_write_sync: captures address and data while a write strobe is
// active and emits a one-clock commit pulse after the end of the strobe
// has passed a SYNC_STAGES-deep synchroniser. Assumes the host holds
// address and data stable while the strobe is low.
module host_write_sync #(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_active,
    input  logic              bank_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit,
    output logic              cap_bank,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);
    logic [SYNC_STAGES:0] chain;

    // Shift the raw write-active level through the synchroniser.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-1:0], wr_active};
    end

    // Hold the bus contents seen during the active strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_bank <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else if (wr_active) begin
            cap_bank <= bank_sel;
            cap_addr <= addr;
            cap_data <= wdata;
        end
    end

    assign commit = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];

    // R10: a commit is a single-clock pulse
    p_commit_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

// File: rtl/digit_store.sv
// digit_store: one code byte per display digit. Writes normalise the
// type bit (character code or glyph index). A clear pulse loads the
// blank code everywhere and wins over a write in the same clock.
module digit_store #(
    parameter int NUM_DIGITS = 8,
    localparam int DIG_W = $clog2(NUM_DIGITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [DIG_W-1:0] wr_idx,
    input  logic [7:0]       wdata,
    input  logic             clear,
    input  logic [DIG_W-1:0] rd_idx,
    output logic [7:0]       rd_code
);
    import disp_host_pkg::*;

    logic [7:0] codes [NUM_DIGITS];
    logic [7:0] norm;

    // Keep only the field that the type bit makes meaningful.
    always_comb begin
        if (wdata[7]) norm = {4'b1000, wdata[3:0]};
        else          norm = {1'b0, wdata[6:0]};
    end

    // Per-digit update: reset or clear to blank, else accept a write.
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                       codes[g] <= BLANK_CODE;
            else if (we && wr_idx == DIG_W'(g))        codes[g] <= norm;
        end
    end

    assign rd_code = codes[rd_idx];

    // R9: after a clear, the leftmost and rightmost digits are blank
    p_clear_blanks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (codes[0] == BLANK_CODE && codes[NUM_DIGITS-1] == BLANK_CODE));
    // R4: a stored glyph index never carries bits 6..4
    p_index_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
        codes[0][7] |-> codes[0][6:4] == 3'b000);
endmodule

// File: rtl/glyph_store.sv
// glyph_store: glyph index register plus the row patterns of all custom
// glyphs. Rows are reached through the index register. Row numbers at
// or above ROWS are neither written nor read (they read as zero).
module glyph_store #(
    parameter int GLYPHS = 16,
    parameter int ROWS   = 7,
    parameter int COLS   = 5,
    localparam int IDX_W = $clog2(GLYPHS),
    localparam int ROW_W = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_idx,
    input  logic             we_row,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [IDX_W-1:0] wr_index,
    input  logic [COLS-1:0]  wr_bits,
    input  logic [ROW_W-1:0] rd_row,
    output logic [IDX_W-1:0] index_q,
    output logic [COLS-1:0]  rd_bits
);
    logic [COLS-1:0] pat [GLYPHS][2**ROW_W];

    // Glyph index register.
    always_ff @(posedge clk) begin
        if (!rst_n)      index_q <= '0;
        else if (we_idx) index_q <= wr_index;
    end

    // Row pattern storage; out-of-range rows are dropped.
    always_ff @(posedge clk) begin
        if (we_row && wr_row < ROW_W'(ROWS)) pat[index_q][wr_row] <= wr_bits;
    end

    assign rd_bits = (rd_row < ROW_W'(ROWS)) ? pat[index_q][rd_row] : '0;

    // R7: the unused row always reads as zero
    p_row_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_row == ROW_W'(ROWS) |-> rd_bits == '0);
    // R5: the index register changes only on its own write
    p_index_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_idx |=> $stable(index_q));
endmodule

// File: rtl/disp_host_regs.sv
// disp_host_regs: top of the display host register file. Decodes the
// strobe bus, commits writes through host_write_sync, holds the control
// word, and muxes read data. Assumes the host keeps only one strobe low
// at a time and keeps the bus stable during a write.
module disp_host_regs #(
    parameter int NUM_DIGITS  = 8,
    parameter int GLYPHS      = 16,
    parameter int ROWS        = 7,
    parameter int COLS        = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       wr_n,
    input  logic       rd_n,
    input  logic       bank_sel,
    input  logic [4:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [7:0] ctrl_word
);
    import disp_host_pkg::*;

    localparam int DIG_W = $clog2(NUM_DIGITS);
    localparam int IDX_W = $clog2(GLYPHS);
    localparam int ROW_W = $clog2(ROWS + 1);

    logic       wr_active, rd_active;
    logic       commit, cap_bank;
    logic [4:0] cap_addr;
    logic [7:0] cap_data;
    logic       we_digit, we_ctrl, we_idx, we_row;
    logic [7:0] ctrl_q, digit_rd;
    logic [IDX_W-1:0] index_q;
    logic [COLS-1:0]  row_rd;
    target_e    wr_tgt, rd_tgt;

    assign wr_active = ~ce_n & ~wr_n & rd_n;
    assign rd_active = ~ce_n & ~rd_n & wr_n & bank_sel;

    host_write_sync #(.SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .wr_active(wr_active), .bank_sel(bank_sel),
        .addr(addr), .wdata(wdata), .commit(commit), .cap_bank(cap_bank),
        .cap_addr(cap_addr), .cap_data(cap_data)
    );

    // Route a committed write to exactly one store.
    always_comb begin
        wr_tgt   = target_e'(cap_addr[4:3]);
        we_digit = commit && cap_bank && wr_tgt == TGT_DIGIT;
        we_ctrl  = commit && cap_bank && wr_tgt == TGT_CTRL;
        we_idx   = commit && cap_bank && wr_tgt == TGT_UDC_IDX;
        we_row   = commit && cap_bank && wr_tgt == TGT_UDC_ROW;
    end

    // Control word; the clear bit drops one clock after it is set.
    always_ff @(posedge clk) begin
        if (!rst_n)              ctrl_q <= '0;
        else if (we_ctrl)        ctrl_q <= cap_data;
        else if (ctrl_q[CTL_CLEAR]) ctrl_q[CTL_CLEAR] <= 1'b0;
    end

    digit_store #(.NUM_DIGITS(NUM_DIGITS)) u_digits (
        .clk(clk), .rst_n(rst_n), .we(we_digit), .wr_idx(cap_addr[DIG_W-1:0]),
        .wdata(cap_data), .clear(ctrl_q[CTL_CLEAR]), .rd_idx(addr[DIG_W-1:0]),
        .rd_code(digit_rd)
    );

    glyph_store #(.GLYPHS(GLYPHS), .ROWS(ROWS), .COLS(COLS)) u_glyphs (
        .clk(clk), .rst_n(rst_n), .we_idx(we_idx), .we_row(we_row),
        .wr_row(cap_addr[ROW_W-1:0]), .wr_index(cap_data[IDX_W-1:0]),
        .wr_bits(cap_data[COLS-1:0]), .rd_row(addr[ROW_W-1:0]),
        .index_q(index_q), .rd_bits(row_rd)
    );

    // Read mux, forced to zero outside an active read.
    always_comb begin
        rd_tgt = target_e'(addr[4:3]);
        rdata  = '0;
        if (rd_active) begin
            unique case (rd_tgt)
                TGT_DIGIT:   rdata = digit_rd;
                TGT_CTRL:    rdata = ctrl_q;
                TGT_UDC_IDX: rdata = 8'(index_q);
                TGT_UDC_ROW: rdata = 8'(row_rd);
            endcase
        end
    end

    assign ctrl_word = ctrl_q;

    // R2: at most one store is written per clock
    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_digit, we_ctrl, we_idx, we_row}));
    // R8: the clear bit never stays set for two clocks
    p_clear_self_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CTL_CLEAR] |=> !ctrl_q[CTL_CLEAR]);
    // R9: clearing leaves the other control bits alone
    p_clear_keeps_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTL_CLEAR] && !we_ctrl) |=> ctrl_q[6:0] == $past(ctrl_q[6:0]));
    // R11: no read, no data
    p_idle_bus_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active |-> rdata == 8'h00);
endmodule

// File: tb/disp_host_regs_bench.sv
// Directed bench for disp_host_regs: one task per scenario.
module disp_host_regs_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, bank_sel = 1'b1;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, ctrl_word;
    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_host_regs u_disp_host_regs (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .rd_n(rd_n),
        .bank_sel(bank_sel), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ctrl_word(ctrl_word)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic bsel, logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        bank_sel = bsel; addr = a; wdata = d; ce_n = 1'b0; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1; ce_n = 1'b1; bank_sel = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic bus_read(logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; ce_n = 1'b0; rd_n = 1'b0;
        #1 d = rdata;
        @(negedge clk);
        rd_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int i = 0; i < 8; i++) begin
            bus_read({2'b11, 3'(i)}, d);
            check("R1 digit blank", d, 8'h20);
        end
        bus_read(5'b00_000, d); check("R1 index", d, 8'h00);
        bus_read(5'b10_000, d); check("R1 ctrl", d, 8'h00);
        check("R1 ctrl_word", ctrl_word, 8'h00);
    endtask

    task automatic t_digits;
        logic [7:0] d;
        for (int i = 0; i < 8; i++) bus_write(1'b1, {2'b11, 3'(i)}, 8'h41 + 8'(i));
        for (int i = 0; i < 8; i++) begin
            bus_read({2'b11, 3'(i)}, d);
            check("R3 digit", d, 8'h41 + 8'(i));
        end
        bus_write(1'b1, 5'b11_010, 8'h9F);
        bus_read(5'b11_010, d); check("R4 glyph index form", d, 8'h8F);
        bus_write(1'b1, 5'b11_011, 8'h7E);
        bus_read(5'b11_011, d); check("R4 char code", d, 8'h7E);
    endtask

    task automatic t_qualify;
        logic [7:0] d;
        @(negedge clk); addr = 5'b11_000; wdata = 8'h55; ce_n = 1'b1; wr_n = 1'b0;
        repeat (3) @(negedge clk); wr_n = 1'b1; repeat (5) @(negedge clk);
        bus_read(5'b11_000, d); check("R2 ce high ignored", d, 8'h41);
        bus_write(1'b0, 5'b11_000, 8'h66);
        bus_read(5'b11_000, d); check("R2 bank 0 ignored", d, 8'h41);
        @(negedge clk); addr = 5'b11_000; bank_sel = 1'b0; ce_n = 1'b0; rd_n = 1'b0;
        #1 check("R11 bank 0 read zero", rdata, 8'h00);
        bank_sel = 1'b1; ce_n = 1'b1;
        #1 check("R11 ce high read zero", rdata, 8'h00);
        rd_n = 1'b1;
    endtask

    task automatic t_glyphs;
        logic [7:0] d;
        bus_write(1'b1, 5'b00_101, 8'hF3);
        bus_read(5'b00_111, d); check("R5 index stored", d, 8'h03);
        for (int r = 0; r < 7; r++) bus_write(1'b1, {2'b01, 3'(r)}, 8'hE0 | 8'(r + 1));
        bus_write(1'b1, 5'b00_000, 8'h09);
        for (int r = 0; r < 7; r++) bus_write(1'b1, {2'b01, 3'(r)}, 8'h1F - 8'(r));
        bus_write(1'b1, 5'b01_111, 8'h1F);
        bus_read(5'b01_111, d); check("R7 row 7 zero", d, 8'h00);
        bus_read(5'b01_110, d); check("R6 glyph 9 row 6", d, 8'h19);
        bus_write(1'b1, 5'b00_000, 8'h03);
        bus_read(5'b01_000, d); check("R6 glyph 3 row 0", d, 8'h01);
        bus_read(5'b01_110, d); check("R6 glyph 3 row 6", d, 8'h07);
    endtask

    task automatic t_ctrl_clear;
        logic [7:0] d;
        @(negedge clk); addr = 5'b10_000; wdata = 8'h03; ce_n = 1'b0; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 no effect mid-strobe", ctrl_word, 8'h00);
        wr_n = 1'b1; ce_n = 1'b1; repeat (5) @(negedge clk);
        check("R10 after strobe", ctrl_word, 8'h03);
        bus_read(5'b10_000, d); check("R8 ctrl readback", d, 8'h03);
        bus_write(1'b1, 5'b10_000, 8'h83);
        check("R8 clear dropped", ctrl_word, 8'h03);
        bus_read(5'b11_010, d); check("R9 digit blanked", d, 8'h20);
        bus_read(5'b11_111, d); check("R9 last digit blanked", d, 8'h20);
        bus_read(5'b00_000, d); check("R9 index kept", d, 8'h03);
        bus_read(5'b01_000, d); check("R9 rows kept", d, 8'h01);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_digits;
        t_qualify;
        t_glyphs;
        t_ctrl_clear;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule